// File: doc/BRIEF.md
# Active Priority Nesting Tracker

This block sits beside one processor's interrupt arbiter and owns the acknowledge and end-of-interrupt steps. When the processor asks to acknowledge, the tracker looks at the ID the arbiter currently offers. It grants the ID only if the ID names an implemented source and its priority is more urgent than the running priority. A grant marks the source active and tells the arbiter to drop its pending state. It also records the source's preemption level in one of two per-group bitmaps.

The running priority is never stored as a number. It is always the lowest set bit found across both bitmaps, scaled back to the 8-bit priority range, or the idle value 0x100 when both bitmaps are empty. Before a priority is recorded, a binary point trims its low bits. The binary point is chosen per group, and each one is clamped to a configured floor. An end-of-interrupt clears the most urgent recorded level of the completing source's group.

The acknowledge path is a valid/ready request with a valid/ready response. A request is taken only when ready is high, and ready is low in two cases: while an earlier response waits unconsumed, and while an end-of-interrupt is presented. A response stays stable until the consumer takes it with ready. The end-of-interrupt input is always ready. The arbiter inputs and the configuration inputs are plain levels.

Top module: `prio_nest_tracker`

## Requirements
- R1: After reset, ack_rsp_valid is 0, run_prio is 0x100, src_active is all zero and pend_clear is all zero.
- R2: ack_req_ready is 0 while a response is held with ack_rsp_ready low, or while eoi_valid is high. A held response keeps ack_rsp_id unchanged. A request that is not accepted changes no state.
- R3: An accepted request is granted when pend_valid is 1, pend_id is below NUM_SRC, and the source priority (8 bits at src_prio[8*id +: 8]) is numerically below run_prio. A grant returns ack_rsp_id = pend_id with bits [12:10] zero, one cycle after acceptance. In the same cycle src_active[id] is set.
- R4: An accepted request that is not granted returns ack_rsp_id 1023 and leaves run_prio, src_active and pend_clear unchanged.
- R5: A grant sets run_prio to the group priority, which is prio AND (0xFF << (bp+1)). Here bp is the effective group-0 binary point. A bp of 7 gives group priority 0.
- R6: When HAS_GROUPS is 1, a source with src_group bit 1 uses the effective group-1 binary point. If cbpr is 1, it uses the group-0 binary point instead.
- R7: The effective group-0 binary point is max(bpr_g0, MIN_BPR). The effective group-1 binary point is max(bpr_g1, MIN_BPR+1).
- R8: Nested grants make run_prio the most urgent (lowest) of all recorded group priorities.
- R9: An accepted end-of-interrupt for source id clears the lowest set bit in the bitmap of that source's group, and clears src_active[id]. run_prio then reflects the remaining levels of both groups on the next cycle.
- R10: An end-of-interrupt with eoi_id at or above NUM_SRC, or one that arrives while run_prio is 0x100, changes neither run_prio nor src_active.
- R11: On a grant, pend_clear pulses for one cycle with only bit id set. The exception is a level-sensitive source (src_edge bit 0) whose src_level bit is 1: its bit is not set, so the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req_valid | input | 1 | Acknowledge request |
| ack_req_ready | output | 1 | Request can be accepted |
| ack_rsp_valid | output | 1 | Response ID available |
| ack_rsp_ready | input | 1 | Consumer takes the response |
| ack_rsp_id | output | 13 | Granted ID, or 1023 when nothing is granted |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_ready | output | 1 | Always 1 |
| eoi_id | input | 10 | ID being completed |
| pend_valid | input | 1 | Arbiter offers a pending ID |
| pend_id | input | 10 | Highest pending ID from the arbiter |
| src_prio | input | 8*NUM_SRC | Per-source priority, source n at bits [8n+7:8n] |
| src_group | input | NUM_SRC | Per-source group, 1 means group 1 |
| src_edge | input | NUM_SRC | 1 means the source is edge-triggered |
| src_level | input | NUM_SRC | Current line level per source |
| bpr_g0 | input | 3 | Group-0 binary point |
| bpr_g1 | input | 3 | Group-1 (aliased) binary point |
| cbpr | input | 1 | Group 1 uses the group-0 binary point |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| src_active | output | NUM_SRC | Active flag per source |
| pend_clear | output | NUM_SRC | One-cycle pending-clear pulse per source |

## Verification
A wrong bit in either active bitmap shows up at run_prio on the cycle after the step that wrote it. Depending on the bit, that is a level that is too urgent, too lax, or not idle after the final completion. Errors in clearing only appear once enough end-of-interrupts have run to expose the stale level, so the bench drains every nest down to idle. Errors in the binary-point path show in the very first run_prio after a grant, which is why that value is swept over every priority and every binary point for each group choice.

// File: rtl/prio_nest_pkg.sv
package prio_nest_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam logic [8:0]  RUN_IDLE = 9'h100;
  localparam logic [12:0] ID_NONE  = 13'd1023;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [2:0]        bpt_t;

  // raise a binary point to its floor
  function automatic bpt_t bp_floor(bpt_t v, int unsigned lo);
    bpt_t l;
    l = 3'(lo);
    return (v < l) ? l : v;
  endfunction
endpackage

// File: rtl/pn_grp_prio.sv
module pn_grp_prio import prio_nest_pkg::*; #(
  parameter int unsigned MIN_BPR    = 2,
  parameter bit          HAS_GROUPS = 1'b1,
  localparam int unsigned LVL_W     = 7 - MIN_BPR
) (
  input  prio_t            prio,
  input  logic             grp1,
  input  logic             cbpr,
  input  bpt_t             bpr_g0,
  input  bpt_t             bpr_g1,
  output logic [LVL_W-1:0] level
);
  bpt_t  bp0_eff, bp1_eff, bp_sel;
  prio_t keep_mask, gprio;

  always_comb begin
    bp0_eff = bp_floor(bpr_g0, MIN_BPR);
    bp1_eff = bp_floor(bpr_g1, MIN_BPR + 1);
    bp_sel  = (HAS_GROUPS && grp1 && !cbpr) ? bp1_eff : bp0_eff;
    keep_mask = 8'hFF << ({1'b0, bp_sel} + 4'd1);
    gprio = prio & keep_mask;
    level = gprio[7:MIN_BPR+1];
  end
endmodule

// File: rtl/pn_lsb_find.sv
module pn_lsb_find #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pn_apr_bank.sv
module pn_apr_bank #(
  parameter int unsigned LVL_W = 5,
  localparam int unsigned NLVL = 1 << LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             drop_en,
  output logic [NLVL-1:0]  bits
);
  logic [NLVL-1:0] nxt;

  always_comb begin
    nxt = bits;
    if (drop_en) nxt = bits & (bits - NLVL'(1));
    if (set_en)  nxt = nxt | (NLVL'(1) << set_lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= nxt;
  end

  assert_drop_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en && !set_en && (bits != '0) |=> $countones(bits) == $countones($past(bits)) - 1);
endmodule

// File: rtl/prio_nest_tracker.sv
module prio_nest_tracker import prio_nest_pkg::*; #(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned MIN_BPR    = 2,
  parameter bit          HAS_GROUPS = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ack_req_valid,
  output logic                 ack_req_ready,
  output logic                 ack_rsp_valid,
  input  logic                 ack_rsp_ready,
  output logic [12:0]          ack_rsp_id,
  input  logic                 eoi_valid,
  output logic                 eoi_ready,
  input  logic [9:0]           eoi_id,
  input  logic                 pend_valid,
  input  logic [9:0]           pend_id,
  input  logic [8*NUM_SRC-1:0] src_prio,
  input  logic [NUM_SRC-1:0]   src_group,
  input  logic [NUM_SRC-1:0]   src_edge,
  input  logic [NUM_SRC-1:0]   src_level,
  input  logic [2:0]           bpr_g0,
  input  logic [2:0]           bpr_g1,
  input  logic                 cbpr,
  output logic [8:0]           run_prio,
  output logic [NUM_SRC-1:0]   src_active,
  output logic [NUM_SRC-1:0]   pend_clear
);
  localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned LVL_W = 7 - MIN_BPR;
  localparam int unsigned NLVL  = 1 << LVL_W;
  localparam int unsigned NGRP  = HAS_GROUPS ? 2 : 1;

  logic [SRC_W-1:0] p_idx, e_idx;
  logic             p_in_range, e_in_range;
  prio_t            p_prio;
  logic             p_grp, e_grp;
  logic             grant, ack_fire, eoi_ok;
  logic [LVL_W-1:0] p_level;
  logic [NLVL-1:0]  apr [2];
  logic [NLVL-1:0]  apr_any;
  logic             lvl_found;
  logic [LVL_W-1:0] lvl_idx;
  logic [NUM_SRC-1:0] set_mask, clr_mask, pc_mask;

  // pending candidate lookup
  always_comb begin
    p_in_range = pend_id < 10'(NUM_SRC);
    p_idx      = pend_id[SRC_W-1:0];
    p_prio     = src_prio[8*int'(p_idx) +: 8];
    p_grp      = HAS_GROUPS ? src_group[p_idx] : 1'b0;
    e_in_range = eoi_id < 10'(NUM_SRC);
    e_idx      = eoi_id[SRC_W-1:0];
    e_grp      = HAS_GROUPS ? src_group[e_idx] : 1'b0;
  end

  pn_grp_prio #(.MIN_BPR(MIN_BPR), .HAS_GROUPS(HAS_GROUPS)) u_gp (
    .prio(p_prio), .grp1(p_grp), .cbpr(cbpr),
    .bpr_g0(bpr_g0), .bpr_g1(bpr_g1), .level(p_level)
  );

  assign eoi_ready     = 1'b1;
  assign ack_req_ready = !(ack_rsp_valid && !ack_rsp_ready) && !eoi_valid;
  assign ack_fire      = ack_req_valid && ack_req_ready;
  assign grant         = pend_valid && p_in_range && ({1'b0, p_prio} < run_prio);
  assign eoi_ok        = eoi_valid && e_in_range && (run_prio != RUN_IDLE);

  // one active-priority bitmap per group
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_bank
      if (g < NGRP) begin : g_live
        pn_apr_bank #(.LVL_W(LVL_W)) u_bank (
          .clk(clk), .rst_n(rst_n),
          .set_en(ack_fire && grant && (p_grp == 1'(g))),
          .set_lvl(p_level),
          .drop_en(eoi_ok && (e_grp == 1'(g))),
          .bits(apr[g])
        );
      end else begin : g_none
        assign apr[g] = '0;
      end
    end
  endgenerate

  assign apr_any = apr[0] | apr[1];

  pn_lsb_find #(.W(NLVL)) u_lsb (.vec(apr_any), .found(lvl_found), .idx(lvl_idx));

  assign run_prio = lvl_found ? {1'b0, lvl_idx, {(MIN_BPR+1){1'b0}}} : RUN_IDLE;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    pc_mask  = '0;
    if (ack_fire && grant) begin
      set_mask[p_idx] = 1'b1;
      pc_mask[p_idx]  = src_edge[p_idx] || !src_level[p_idx];
    end
    if (eoi_ok) clr_mask[e_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_rsp_valid <= 1'b0;
      ack_rsp_id    <= ID_NONE;
      src_active    <= '0;
      pend_clear    <= '0;
    end else begin
      src_active <= (src_active | set_mask) & ~clr_mask;
      pend_clear <= pc_mask;
      if (ack_fire) begin
        ack_rsp_valid <= 1'b1;
        ack_rsp_id    <= grant ? {3'b000, pend_id} : ID_NONE;
      end else if (ack_rsp_ready) begin
        ack_rsp_valid <= 1'b0;
      end
    end
  end

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rsp_valid && !ack_rsp_ready |=> ack_rsp_valid && $stable(ack_rsp_id));
  assert_grant_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && grant |=> run_prio < $past(run_prio));
  assert_no_side_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_fire && grant) && !eoi_valid |=> $stable(run_prio) && $stable(src_active));
  assert_eoi_never_tightens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_ok |=> run_prio >= $past(run_prio));
  assert_eoi_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && !e_in_range |=> $stable(src_active) && $stable(run_prio));
  assert_clear_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clear));
endmodule

// File: tb/sim_prio_nest_tracker.sv
module sim_prio_nest_tracker;
  localparam int NUM_SRC = 32;
  localparam int MIN_BPR = 2;
  localparam int CLK_HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_req_valid = 1'b0, ack_rsp_ready = 1'b1;
  logic ack_req_ready, ack_rsp_valid, eoi_ready;
  logic [12:0] ack_rsp_id;
  logic eoi_valid = 1'b0;
  logic [9:0] eoi_id = '0;
  logic pend_valid = 1'b0;
  logic [9:0] pend_id = '0;
  logic [8*NUM_SRC-1:0] src_prio = '0;
  logic [NUM_SRC-1:0] src_group = '0, src_edge = '1, src_level = '0;
  logic [2:0] bpr_g0 = '0, bpr_g1 = '0;
  logic cbpr = 1'b0;
  logic [8:0] run_prio;
  logic [NUM_SRC-1:0] src_active, pend_clear;

  int checks = 0;
  int fails = 0;

  always #CLK_HALF clk = ~clk;

  prio_nest_tracker #(.NUM_SRC(NUM_SRC), .MIN_BPR(MIN_BPR), .HAS_GROUPS(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ack_req_valid(ack_req_valid), .ack_req_ready(ack_req_ready),
    .ack_rsp_valid(ack_rsp_valid), .ack_rsp_ready(ack_rsp_ready), .ack_rsp_id(ack_rsp_id),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_id(eoi_id),
    .pend_valid(pend_valid), .pend_id(pend_id),
    .src_prio(src_prio), .src_group(src_group), .src_edge(src_edge), .src_level(src_level),
    .bpr_g0(bpr_g0), .bpr_g1(bpr_g1), .cbpr(cbpr),
    .run_prio(run_prio), .src_active(src_active), .pend_clear(pend_clear)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gp_of(input int prio, input int grp, input int c, input int b0, input int b1);
    int bp;
    int e0 = (b0 < MIN_BPR) ? MIN_BPR : b0;
    int e1 = (b1 < MIN_BPR + 1) ? MIN_BPR + 1 : b1;
    bp = (grp == 1 && c == 0) ? e1 : e0;
    return prio & ((32'hFF << (bp + 1)) & 32'hFF);
  endfunction

  task automatic set_src(input int id, input int prio, input int grp);
    src_prio[8*id +: 8] = 8'(prio);
    src_group[id] = 1'(grp);
  endtask

  // request one acknowledge for id; sample one cycle later
  task automatic do_ack(input int id);
    @(negedge clk);
    pend_valid = 1'b1;
    pend_id = 10'(id);
    ack_req_valid = 1'b1;
    @(negedge clk);
    ack_req_valid = 1'b0;
  endtask

  task automatic do_eoi(input int id);
    @(negedge clk);
    eoi_valid = 1'b1;
    eoi_id = 10'(id);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", ack_rsp_valid, 0);
    chk("R1 run_prio", run_prio, 9'h100);
    chk("R1 active", src_active, 0);
    chk("R1 pend_clear", pend_clear, 0);

    // R5 R6 R7 sweep: every priority, every binary point, three group choices
    for (int mode = 0; mode < 3; mode++) begin
      for (int b = 0; b < 8; b++) begin
        for (int p = 0; p < 256; p++) begin
          int id = p % NUM_SRC;
          int grp = (mode == 0) ? 0 : 1;
          int c = (mode == 2) ? 1 : 0;
          int b0 = (mode == 1) ? 7 - b : b;
          int exp;
          set_src(id, p, grp);
          bpr_g0 = 3'(b0);
          bpr_g1 = 3'(b);
          cbpr = 1'(c);
          exp = gp_of(p, grp, c, b0, b);
          do_ack(id);
          chk("R3 sweep id", ack_rsp_id, id);
          if (mode == 0) chk("R5 sweep run_prio", run_prio, exp);
          else if (mode == 1) chk("R6 R7 sweep run_prio", run_prio, exp);
          else chk("R6 cbpr sweep run_prio", run_prio, exp);
          do_eoi(id);
          chk("R9 sweep idle", run_prio, 9'h100);
        end
      end
    end

    bpr_g0 = 3'd0;
    bpr_g1 = 3'd0;
    cbpr = 1'b0;
    // R8 nesting and R4 rejection
    set_src(1, 8'hC0, 0);
    set_src(2, 8'h40, 0);
    set_src(3, 8'h80, 0);
    do_ack(1);
    chk("R3 active", src_active, 32'h2);
    chk("R11 edge pend_clear", pend_clear, 32'h2);
    do_ack(2);
    chk("R8 nested run_prio", run_prio, 8'h40);
    do_ack(3);
    chk("R4 reject id", ack_rsp_id, 1023);
    chk("R4 reject run_prio", run_prio, 8'h40);
    chk("R4 reject active", src_active, 32'h6);
    chk("R4 reject pend_clear", pend_clear, 0);
    // R10 out-of-range EOI
    do_eoi(40);
    chk("R10 range run_prio", run_prio, 8'h40);
    chk("R10 range active", src_active, 32'h6);
    do_eoi(2);
    chk("R9 unnest run_prio", run_prio, 8'hC0);
    chk("R9 unnest active", src_active, 32'h2);
    do_eoi(1);
    chk("R9 drained", run_prio, 9'h100);
    do_eoi(1);
    chk("R10 idle eoi", run_prio, 9'h100);
    chk("R10 idle active", src_active, 0);

    // R9 group separation
    set_src(4, 8'h80, 0);
    set_src(5, 8'h20, 1);
    do_ack(4);
    do_ack(5);
    chk("R9 two groups", run_prio, 8'h20);
    do_eoi(4);
    chk("R9 group0 drop keeps group1", run_prio, 8'h20);
    chk("R9 group0 active", src_active, 32'h20);
    do_eoi(5);
    chk("R9 group1 drop", run_prio, 9'h100);

    // R4 invalid pending
    @(negedge clk);
    pend_valid = 1'b0;
    ack_req_valid = 1'b1;
    @(negedge clk);
    ack_req_valid = 1'b0;
    chk("R4 no pending id", ack_rsp_id, 1023);
    do_ack(NUM_SRC + 3);
    chk("R4 out of range id", ack_rsp_id, 1023);
    chk("R4 out of range run_prio", run_prio, 9'h100);

    // R11 level-sensitive handling
    set_src(6, 8'h10, 0);
    src_edge[6] = 1'b0;
    src_level[6] = 1'b1;
    do_ack(6);
    chk("R11 level high keeps pending", pend_clear, 0);
    do_eoi(6);
    src_level[6] = 1'b0;
    do_ack(6);
    chk("R11 level low clears", pend_clear, 32'h40);
    @(negedge clk);
    chk("R11 pulse one cycle", pend_clear, 0);
    do_eoi(6);

    // R2 back-pressure
    ack_rsp_ready = 1'b0;
    set_src(7, 8'h90, 0);
    set_src(8, 8'h08, 0);
    do_ack(7);
    chk("R2 rsp id", ack_rsp_id, 7);
    chk("R2 ready low while held", ack_req_ready, 0);
    do_ack(8);
    chk("R2 held id stable", ack_rsp_id, 7);
    chk("R2 blocked run_prio", run_prio, 8'h90);
    ack_rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 rsp drained", ack_rsp_valid, 0);
    eoi_valid = 1'b1;
    eoi_id = 10'd40;
    #1;
    chk("R2 ready low on eoi", ack_req_ready, 0);
    @(negedge clk);
    eoi_valid = 1'b0;
    do_eoi(7);
    chk("R2 final idle", run_prio, 9'h100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule